// File: doc/BRIEF.md
# Sprite Attribute Memory with Page Copy Engine

This block holds a 256-byte table of sprite attributes and gives the processor three register slots to reach it: a pointer slot that sets the table index, a data slot that reads or writes the byte at that index, and a page slot that starts a bulk copy. A write through the data slot stores the byte and then moves the pointer on by one. A read through the data slot leaves the pointer where it is.

Writing a page number P to the page slot starts the copy engine. The engine reads the 256 processor-space bytes from P×256 to P×256+255 in ascending order over a read-only master port. It stores each byte into the table at the current pointer, and the pointer advances after every byte. The engine spends one cycle issuing a read and one cycle storing the returned byte, so a copy takes 512 cycles. During the copy it raises a hold signal, which tells the processor side that the external bus is taken. The engine is a three-state machine. The states are IDLE, FETCH and STORE. The transitions are START (IDLE to FETCH on an accepted page write), ISSUE (FETCH to STORE), NEXT (STORE to FETCH while bytes remain) and DONE (STORE to IDLE after the 256th byte).

Top module: `spr_mem_dma`

## Requirements
- R1: After reset, the pointer is 0x00 and `bus_hold`, `mem_rd_req` and `reg_rdata` are all zero.
- R2: A write with `reg_sel` = 2'b00 loads `reg_wdata` into the pointer.
- R3: A write with `reg_sel` = 2'b01 stores `reg_wdata` at the pointer and then increments the pointer. The pointer wraps from 0xFF to 0x00.
- R4: A read with `reg_sel` = 2'b01 places the byte at the pointer on `reg_rdata` one cycle later and leaves the pointer unchanged.
- R5: A write of P with `reg_sel` = 2'b10 while idle starts a copy. The copy issues reads to addresses {P, 0x00} through {P, 0xFF} in ascending order. The first request appears in the cycle after the write. `mem_rdata` is taken one cycle after each request.
- R6: Copied bytes land at the pointer value current at the start and at the values that follow it, wrapping from 0xFF to 0x00. The pointer ends back at its start value.
- R7: Read requests come on every other cycle, giving two cycles per byte.
- R8: `bus_hold` is high for exactly 512 consecutive cycles per copy, and `mem_rd_req` is only high while `bus_hold` is high.
- R9: While a copy is active, writes to any slot are ignored. This includes a second page write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Slot select: 00 pointer, 01 data, 10 page, 11 unused |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Data slot read result, registered |
| mem_rd_req | output | 1 | Copy engine read request |
| mem_addr | output | 16 | Copy engine read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| bus_hold | output | 1 | High while a copy owns the bus |

## Verification
The tests write bytes one after another through the data slot and read them back. This shows that the pointer increments on writes but not on reads. One write run crosses 0xFF and shows that the pointer wraps. The first copy starts with the pointer at zero and the second starts at 0xF0. Comparing the two separates an engine that begins at the current pointer and wraps from one that always begins at index zero. Writes to all three slots are issued during the second copy, so any write the engine fails to ignore would show up in the request stream, the hold length or the table contents.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [1:0] {
        SEL_PTR  = 2'b00,
        SEL_DATA = 2'b01,
        SEL_PAGE = 2'b10,
        SEL_NONE = 2'b11
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } dma_state_e;
endpackage

// File: rtl/spr_ram.sv
module spr_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign q = cells[addr];
endmodule

// File: rtl/spr_port.sv
module spr_port
    import spr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          busy,
    input  logic          dma_inc,
    input  logic [DW-1:0] ram_q,
    output logic [AW-1:0] ptr,
    output logic          cpu_we,
    output logic          dma_start,
    output logic [DW-1:0] rd_data
);
    slot_e slot;
    logic  wr_ok;

    assign slot      = slot_e'(reg_sel);
    assign wr_ok     = reg_wr && !busy;
    assign cpu_we    = wr_ok && (slot == SEL_DATA);
    assign dma_start = wr_ok && (slot == SEL_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_ok && slot == SEL_PTR) begin
            ptr <= reg_wdata[AW-1:0];
        end else if (cpu_we || dma_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (reg_rd && slot == SEL_DATA) begin
            rd_data <= ram_q;
        end
    end
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CPU_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PW-1:0]     page_in,
    output logic              busy,
    output logic              mem_rd_req,
    output logic [CPU_AW-1:0] mem_addr,
    output logic              dma_we
);
    localparam int PW = CPU_AW - AW;

    dma_state_e        state, state_nx;
    logic [AW-1:0]     idx;
    logic [PW-1:0]     page;
    logic              last;

    assign last = (idx == {AW{1'b1}});

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_STORE;
            ST_STORE: state_nx = last ? ST_IDLE : ST_FETCH;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            page <= '0;
        end else if (state == ST_IDLE && start) begin
            idx  <= '0;
            page <= page_in;
        end else if (state == ST_STORE) begin
            idx  <= idx + 1'b1;
        end
    end

    always_comb begin
        busy       = 1'b0;
        mem_rd_req = 1'b0;
        dma_we     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_FETCH: begin busy = 1'b1; mem_rd_req = 1'b1; end
            ST_STORE: begin busy = 1'b1; dma_we = 1'b1; end
            default:  ;
        endcase
    end

    assign mem_addr = {page, idx};
endmodule

// File: rtl/spr_mem_dma.sv
module spr_mem_dma #(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int CPU_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_rd_req,
    output logic [CPU_AW-1:0] mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              bus_hold
);
    localparam int PW = CPU_AW - AW;

    logic [AW-1:0] ptr;
    logic          cpu_we, dma_we, dma_start, busy;
    logic [DW-1:0] ram_q, ram_wdata;

    spr_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .busy(busy),
        .dma_inc(dma_we), .ram_q(ram_q), .ptr(ptr), .cpu_we(cpu_we),
        .dma_start(dma_start), .rd_data(reg_rdata)
    );

    spr_dma_seq #(.AW(AW), .CPU_AW(CPU_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(dma_start),
        .page_in(reg_wdata[PW-1:0]), .busy(busy),
        .mem_rd_req(mem_rd_req), .mem_addr(mem_addr), .dma_we(dma_we)
    );

    assign ram_wdata = dma_we ? mem_rdata : reg_wdata;

    spr_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(cpu_we | dma_we), .addr(ptr),
        .wdata(ram_wdata), .q(ram_q)
    );

    assign bus_hold = busy;
endmodule

// File: rtl/spr_chk.sv
module spr_chk #(
    parameter int AW     = 8,
    parameter int CPU_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic              bus_hold,
    input logic              mem_rd_req,
    input logic [CPU_AW-1:0] mem_addr
);
    localparam int HOLD_LEN = 2 * (1 << AW);

    int run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run <= 0;
        else if (bus_hold) run <= run + 1;
        else               run <= 0;
    end

    a_r8_req_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> bus_hold);

    a_r7_req_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> ##2 (!mem_rd_req || mem_addr == $past(mem_addr, 2) + 1'b1));

    a_r5_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hold) |-> $past(reg_wr && reg_sel == 2'b10));

    a_r8_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hold) |-> run == HOLD_LEN);

    a_r8_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
        run <= HOLD_LEN);
endmodule

bind spr_mem_dma spr_chk #(.AW(AW), .CPU_AW(CPU_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .bus_hold(bus_hold), .mem_rd_req(mem_rd_req), .mem_addr(mem_addr)
);

// File: tb/spr_mem_dma_test.sv
module spr_mem_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'b00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_rd_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        bus_hold;

    int total = 0, bad = 0, cyc = 0, hold_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spr_mem_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .bus_hold(bus_hold)
    );

    function automatic [7:0] mf(input [15:0] a);
        mf = (a[7:0] * 8'd7) + (a[15:8] ^ 8'h3C);
    endfunction

    always @(posedge clk) if (mem_rd_req) mem_rdata <= mf(mem_addr);

    // behavioural reference
    byte unsigned spr [256];
    int  m_ptr = 0, m_k = 0, m_phase = 0, m_page = 0;
    bit  m_busy = 0;
    byte unsigned m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_busy = 0; m_rd = 0; m_k = 0; m_phase = 0;
        end else begin
            if (reg_rd && reg_sel == 2'b01) m_rd = spr[m_ptr];
            if (m_busy) begin
                if (m_phase == 0) m_phase = 1;
                else begin
                    spr[m_ptr] = mf(16'(m_page * 256 + m_k));
                    m_ptr = (m_ptr + 1) % 256;
                    if (m_k == 255) m_busy = 0; else m_k++;
                    m_phase = 0;
                end
            end else if (reg_wr) begin
                case (reg_sel)
                    2'b00: m_ptr = reg_wdata;
                    2'b01: begin spr[m_ptr] = reg_wdata; m_ptr = (m_ptr + 1) % 256; end
                    2'b10: begin m_busy = 1; m_k = 0; m_phase = 0; m_page = reg_wdata; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) if (rst_n && !done) begin
        cyc++;
        if (bus_hold) hold_cnt++;
        chk("R8 bus_hold", bus_hold, m_busy);
        chk("R7 mem_rd_req", mem_rd_req, m_busy && m_phase == 0);
        if (m_busy && m_phase == 0) chk("R5 mem_addr", mem_addr, m_page * 256 + m_k);
        chk("R4 reg_rdata", reg_rdata, m_rd);
        if (cyc > 100000) begin
            chk("watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input [1:0] s, input [7:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_at(input [7:0] a, input string tag, input [7:0] exp);
        wr(2'b00, a);
        reg_rd = 1; reg_sel = 2'b01;
        @(negedge clk); reg_rd = 0;
        @(posedge clk); #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (bus_hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hold", bus_hold, 0);
        chk("R1 req", mem_rd_req, 0);
        chk("R1 rdata", reg_rdata, 0);
        rst_n = 1;
        // R1 pointer at zero: data write lands at 0
        wr(2'b01, 8'h77);
        rd_at(8'h00, "R1 ptr", 8'h77);
        // R2/R3 sequential writes
        wr(2'b00, 8'h10);
        wr(2'b01, 8'hA1); wr(2'b01, 8'hA2); wr(2'b01, 8'hA3);
        rd_at(8'h11, "R3 seq", 8'hA2);
        rd_at(8'h12, "R2 R3 seq", 8'hA3);
        // R4 repeated read leaves pointer
        reg_rd = 1; reg_sel = 2'b01;
        @(negedge clk); @(negedge clk); reg_rd = 0;
        wr(2'b01, 8'h5E);
        rd_at(8'h12, "R4 no inc", 8'h5E);
        // R3 wrap
        wr(2'b00, 8'hFF);
        wr(2'b01, 8'hC0); wr(2'b01, 8'hC1);
        rd_at(8'h00, "R3 wrap", 8'hC1);
        // copy from zero
        wr(2'b00, 8'h00);
        hold_cnt = 0;
        wr(2'b10, 8'h03);
        wait_idle();
        chk("R8 len", hold_cnt, 512);
        rd_at(8'h00, "R5 first", mf(16'h0300));
        rd_at(8'hFF, "R5 last", mf(16'h03FF));
        // copy from 0xF0 with writes during it
        wr(2'b00, 8'hF0);
        hold_cnt = 0;
        wr(2'b10, 8'hA5);
        repeat (20) @(negedge clk);
        wr(2'b10, 8'h11);
        wr(2'b00, 8'h40);
        wr(2'b01, 8'hEE);
        wait_idle();
        chk("R9 R8 len", hold_cnt, 512);
        reg_rd = 1; reg_sel = 2'b01;
        @(negedge clk); reg_rd = 0;
        @(posedge clk); #1;
        chk("R6 end ptr", reg_rdata, mf(16'hA500));
        rd_at(8'h00, "R6 wrap", mf(16'hA510));
        rd_at(8'hEF, "R6 tail", mf(16'hA5FF));
        rd_at(8'h40, "R9 data", mf(16'hA550));
        for (int i = 0; i < 256; i += 37) rd_at(i[7:0], "R6 scan", spr[i]);
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule